// File: doc/BRIEF.md
# VME Bootloader Slave Controller

This block is a small VME slave for a bootloader FPGA. Each bus cycle is checked against a board base address, one accepted address-modifier code and one accepted transfer width. The offset must also fall inside a narrow window of programming registers. A cycle that passes all of these checks becomes a single register access on a local port that drives a configuration engine. The block answers that access with a data-transfer acknowledge.

The bus side is a simplified parallel slave port. The address strobe and the two data strobes pass through a two-flop synchronizer. Address, modifier and width flag are captured on the synchronized falling edge of the address strobe. Read data is driven through a separate output and enable pair rather than a bidirectional pin. A decode that fails returns the controller to idle at once. The next address strobe is then decoded from a clean start.

Top module: `boot_vme_slave`

## Requirements
- R1: After reset, vme_dtack_n is 1, vme_data_oe is 0, and eng_we and eng_re are 0.
- R2: A write cycle whose base (address bits 23:19 equal to cfg_base), modifier (0x39), width (vme_lword_n high) and offset (bits 18:0) all match gives exactly one one-cycle eng_we pulse. That pulse carries eng_addr = offset - 0x70000 and eng_wdata = vme_data_i, and vme_dtack_n goes low at the same edge.
- R3: A matching read cycle gives one eng_re pulse. On the next edge, vme_data_o takes eng_rdata for that eng_addr, and vme_data_oe and vme_dtack_n are asserted at that same edge.
- R4: The byte lanes follow the strobe index: eng_be[0] = ~vme_ds_n[0] (bits 7:0) and eng_be[1] = ~vme_ds_n[1] (bits 15:8).
- R5: The window is inclusive, 0x70000 to 0x70020. Offsets 0x70000 and 0x70020 are served. Offsets 0x6FFFE and 0x70022 get no acknowledge and no local strobe.
- R6: A wrong base, a wrong modifier, or a 32-bit width (vme_lword_n low) gets no acknowledge and no local strobe.
- R7: The decode state lasts exactly one cycle, and a rejected decode goes back to idle. Holding the address strobe low after a rejection, even while the address changes to a valid one, gives no response. The next new falling edge of the strobe is decoded fresh, so a valid cycle right after a rejected one is acknowledged.
- R8: vme_dtack_n stays low while either synchronized data strobe is low. Three cycles after both strobes go high, vme_dtack_n is 1 and vme_data_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 5 | Board base address, compared with address bits 23:19 |
| vme_addr | input | 24 | Bus address |
| vme_am | input | 6 | Address modifier |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds_n | input | 2 | Data strobes, active low, index equals lane |
| vme_write_n | input | 1 | Low for write, high for read |
| vme_lword_n | input | 1 | Low requests a 32-bit transfer (rejected) |
| vme_data_i | input | 16 | Write data from the bus |
| vme_data_o | output | 16 | Read data to the bus |
| vme_data_oe | output | 1 | Read data drive enable |
| vme_dtack_n | output | 1 | Data-transfer acknowledge, active low |
| eng_we | output | 1 | One-cycle write strobe to the engine |
| eng_re | output | 1 | One-cycle read strobe to the engine |
| eng_addr | output | 6 | Offset relative to the window start |
| eng_be | output | 2 | Byte enables |
| eng_wdata | output | 16 | Write data to the engine |
| eng_rdata | input | 16 | Read data from the engine |

## Verification
Strobes, address and data are all driven on one falling clock edge. Counted from that edge, the acknowledge of a write is due five cycles later and that of a read six cycles later: two synchronizer flops, edge detect, decode, execute, and one read latch. The release of the acknowledge is due three cycles after the strobes rise. The bench counts falling edges until each event and compares the count with these exact numbers. A monitor pops the expected engine strobes from a queue on the falling edge where each one appears, so a missing, extra or misplaced strobe is caught at the cycle it happens. Rejected cycles are watched for twelve cycles, so a late acknowledge would also be caught.

// File: rtl/bvs_pkg.sv
package bvs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_EXEC,
    ST_RDLATCH,
    ST_ACK
  } bvs_state_e;
endpackage

// File: rtl/bvs_sync.sv
module bvs_sync #(
  parameter int W       = 3,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL;
        s2 <= RST_VAL;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/bvs_match.sv
module bvs_match #(
  parameter int          ADDR_W = 24,
  parameter int          BASE_W = 5,
  parameter int          AM_W   = 6,
  parameter logic [5:0]  ACC_AM = 6'h39,
  parameter int unsigned WIN_LO = 'h70000,
  parameter int unsigned WIN_HI = 'h70020,
  parameter int          LP_AW  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [AM_W-1:0]   am,
  input  logic              lword_n,
  input  logic [BASE_W-1:0] base,
  output logic              hit,
  output logic [LP_AW-1:0]  rel
);
  localparam int OFS_W = ADDR_W - BASE_W;

  logic [OFS_W-1:0] ofs, diff;
  logic base_ok, am_ok, win_ok;

  assign ofs     = addr[OFS_W-1:0];
  assign diff    = ofs - OFS_W'(WIN_LO);
  assign base_ok = (addr[ADDR_W-1 -: BASE_W] == base);
  assign am_ok   = (am == AM_W'(ACC_AM));
  assign win_ok  = (ofs >= OFS_W'(WIN_LO)) && (ofs <= OFS_W'(WIN_HI));
  assign hit     = base_ok && am_ok && lword_n && win_ok;
  assign rel     = diff[LP_AW-1:0];
endmodule

// File: rtl/bvs_ctrl.sv
module bvs_ctrl
  import bvs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int AM_W   = 6,
  parameter int DATA_W = 16,
  parameter int LP_AW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as_s,
  input  logic [1:0]        ds_s,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [AM_W-1:0]   bus_am,
  input  logic              bus_lword_n,
  input  logic              bus_write_n,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [AM_W-1:0]   lat_am,
  output logic              lat_lword_n,
  input  logic              hit,
  input  logic [LP_AW-1:0]  rel,
  input  logic [DATA_W-1:0] eng_rdata,
  output logic              eng_we,
  output logic              eng_re,
  output logic [LP_AW-1:0]  eng_addr,
  output logic [1:0]        eng_be,
  output logic [DATA_W-1:0] eng_wdata,
  output logic [DATA_W-1:0] dout,
  output logic              oe,
  output logic              dtack_n
);
  bvs_state_e state;
  logic as_prev, lat_write_n;
  logic as_fall;

  assign as_fall = as_prev & ~as_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      as_prev     <= 1'b1;
      lat_addr    <= '0;
      lat_am      <= '0;
      lat_lword_n <= 1'b1;
      lat_write_n <= 1'b1;
      eng_we      <= 1'b0;
      eng_re      <= 1'b0;
      eng_addr    <= '0;
      eng_be      <= '0;
      eng_wdata   <= '0;
      dout        <= '0;
      oe          <= 1'b0;
      dtack_n     <= 1'b1;
    end else begin
      as_prev <= as_s;
      eng_we  <= 1'b0;
      eng_re  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (as_fall) begin
            lat_addr    <= bus_addr;
            lat_am      <= bus_am;
            lat_lword_n <= bus_lword_n;
            lat_write_n <= bus_write_n;
            state       <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          state <= ST_IDLE;
          if (hit) begin
            eng_addr <= rel;
            state    <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (ds_s != 2'b11) begin
            eng_be <= ~ds_s;
            if (!lat_write_n) begin
              eng_wdata <= bus_din;
              eng_we    <= 1'b1;
              dtack_n   <= 1'b0;
              state     <= ST_ACK;
            end else begin
              eng_re <= 1'b1;
              state  <= ST_RDLATCH;
            end
          end else if (as_s) begin
            state <= ST_IDLE;
          end
        end
        ST_RDLATCH: begin
          dout    <= eng_rdata;
          oe      <= 1'b1;
          dtack_n <= 1'b0;
          state   <= ST_ACK;
        end
        ST_ACK: begin
          if (ds_s == 2'b11) begin
            dtack_n <= 1'b1;
            oe      <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DECODE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    state == ST_DECODE |=> state != ST_DECODE); // R7
  AST_REJECT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && !hit) |=> state == ST_IDLE); // R7
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    eng_we |=> !eng_we); // R2
  AST_STROBE_LANES: assert property (@(posedge clk) disable iff (rst)
    (eng_we || eng_re) |-> eng_be != 2'b00); // R4
  AST_DTACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n && ds_s != 2'b11) |=> !dtack_n); // R8
  AST_RD_DATA_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    ($fell(dtack_n) && lat_write_n) |-> oe); // R3
endmodule

// File: rtl/boot_vme_slave.sv
module boot_vme_slave #(
  parameter int          ADDR_W = 24,
  parameter int          BASE_W = 5,
  parameter int          AM_W   = 6,
  parameter int          DATA_W = 16,
  parameter logic [5:0]  ACC_AM = 6'h39,
  parameter int unsigned WIN_LO = 'h70000,
  parameter int unsigned WIN_HI = 'h70020,
  localparam int         LP_AW  = $clog2(WIN_HI - WIN_LO + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] vme_addr,
  input  logic [AM_W-1:0]   vme_am,
  input  logic              vme_as_n,
  input  logic [1:0]        vme_ds_n,
  input  logic              vme_write_n,
  input  logic              vme_lword_n,
  input  logic [DATA_W-1:0] vme_data_i,
  output logic [DATA_W-1:0] vme_data_o,
  output logic              vme_data_oe,
  output logic              vme_dtack_n,
  output logic              eng_we,
  output logic              eng_re,
  output logic [LP_AW-1:0]  eng_addr,
  output logic [1:0]        eng_be,
  output logic [DATA_W-1:0] eng_wdata,
  input  logic [DATA_W-1:0] eng_rdata
);
  logic [2:0]        strb_s;
  logic [ADDR_W-1:0] lat_addr;
  logic [AM_W-1:0]   lat_am;
  logic              lat_lword_n;
  logic              hit;
  logic [LP_AW-1:0]  rel;

  bvs_sync #(.W(3), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({vme_ds_n, vme_as_n}),
    .q   (strb_s)
  );

  bvs_match #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .AM_W(AM_W), .ACC_AM(ACC_AM),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .LP_AW(LP_AW)
  ) u_match (
    .addr    (lat_addr),
    .am      (lat_am),
    .lword_n (lat_lword_n),
    .base    (cfg_base),
    .hit     (hit),
    .rel     (rel)
  );

  bvs_ctrl #(
    .ADDR_W(ADDR_W), .AM_W(AM_W), .DATA_W(DATA_W), .LP_AW(LP_AW)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .as_s        (strb_s[0]),
    .ds_s        (strb_s[2:1]),
    .bus_addr    (vme_addr),
    .bus_am      (vme_am),
    .bus_lword_n (vme_lword_n),
    .bus_write_n (vme_write_n),
    .bus_din     (vme_data_i),
    .lat_addr    (lat_addr),
    .lat_am      (lat_am),
    .lat_lword_n (lat_lword_n),
    .hit         (hit),
    .rel         (rel),
    .eng_rdata   (eng_rdata),
    .eng_we      (eng_we),
    .eng_re      (eng_re),
    .eng_addr    (eng_addr),
    .eng_be      (eng_be),
    .eng_wdata   (eng_wdata),
    .dout        (vme_data_o),
    .oe          (vme_data_oe),
    .dtack_n     (vme_dtack_n)
  );
endmodule

// File: tb/boot_vme_slave_tb_top.sv
module boot_vme_slave_tb_top;
  localparam logic [4:0] BASE = 5'h0B;
  localparam logic [5:0] AM_OK = 6'h39;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] vme_addr = '0;
  logic [5:0]  vme_am = '0;
  logic        vme_as_n = 1'b1;
  logic [1:0]  vme_ds_n = 2'b11;
  logic        vme_write_n = 1'b1;
  logic        vme_lword_n = 1'b1;
  logic [15:0] vme_data_i = '0;
  logic [15:0] vme_data_o;
  logic        vme_data_oe, vme_dtack_n;
  logic        eng_we, eng_re;
  logic [5:0]  eng_addr;
  logic [1:0]  eng_be;
  logic [15:0] eng_wdata, eng_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    bit          wr;
    logic [5:0]  a;
    logic [1:0]  be;
    logic [15:0] d;
    string       req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  function automatic logic [15:0] rd_model(input logic [5:0] a);
    return {8'hA5, 2'b00, a};
  endfunction
  assign eng_rdata = rd_model(eng_addr);

  boot_vme_slave dut_i (
    .clk(clk), .rst(rst), .cfg_base(BASE),
    .vme_addr(vme_addr), .vme_am(vme_am), .vme_as_n(vme_as_n),
    .vme_ds_n(vme_ds_n), .vme_write_n(vme_write_n), .vme_lword_n(vme_lword_n),
    .vme_data_i(vme_data_i), .vme_data_o(vme_data_o), .vme_data_oe(vme_data_oe),
    .vme_dtack_n(vme_dtack_n), .eng_we(eng_we), .eng_re(eng_re),
    .eng_addr(eng_addr), .eng_be(eng_be), .eng_wdata(eng_wdata),
    .eng_rdata(eng_rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected engine strobes
  always @(negedge clk) begin
    if (!rst && (eng_we || eng_re)) begin
      if (q.size() == 0) begin
        chk("R5 R6", "unexpected engine strobe", {30'd0, eng_we, eng_re}, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, "strobe kind", {31'd0, eng_we}, {31'd0, e.wr});
        chk(e.req, "eng_addr", {26'd0, eng_addr}, {26'd0, e.a});
        chk("R4", "eng_be", {30'd0, eng_be}, {30'd0, e.be});
        if (e.wr) chk(e.req, "eng_wdata", {16'd0, eng_wdata}, {16'd0, e.d});
      end
    end
  end

  task automatic release_and_check(input string req);
    int cnt;
    vme_as_n = 1'b1;
    vme_ds_n = 2'b11;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cnt++;
      if (vme_dtack_n) break;
    end
    chk(req, "dtack release latency", cnt, 3);
    chk(req, "oe after release", {31'd0, vme_data_oe}, 0);
  endtask

  task automatic drive(input logic [4:0] base, input logic [18:0] ofs,
                       input logic [5:0] am, input logic lw_n, input logic wr_n,
                       input logic [1:0] ds, input logic [15:0] wd);
    vme_addr    = {base, ofs};
    vme_am      = am;
    vme_lword_n = lw_n;
    vme_write_n = wr_n;
    vme_ds_n    = ds;
    vme_data_i  = wd;
    vme_as_n    = 1'b0;
  endtask

  task automatic good_cycle(input logic [18:0] ofs, input bit wr,
                            input logic [1:0] ds, input logic [15:0] wd,
                            input string req);
    exp_t e;
    int cnt;
    logic [18:0] rel;
    @(negedge clk);
    rel = ofs - 19'h70000;
    e.wr = wr; e.a = rel[5:0]; e.be = ~ds; e.d = wd; e.req = req;
    q.push_back(e);
    drive(BASE, ofs, AM_OK, 1'b1, !wr, ds, wd);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cnt++;
      if (!vme_dtack_n) break;
    end
    chk(req, "ack latency", cnt, wr ? 5 : 6);
    if (!wr) begin
      chk("R3", "read data", {16'd0, vme_data_o}, {16'd0, rd_model(rel[5:0])});
      chk("R3", "read oe", {31'd0, vme_data_oe}, 1);
    end
    release_and_check("R8");
  endtask

  task automatic bad_cycle(input logic [4:0] base, input logic [18:0] ofs,
                           input logic [5:0] am, input logic lw_n, input string req);
    bit acked;
    @(negedge clk);
    drive(base, ofs, am, lw_n, 1'b0, 2'b00, 16'hDEAD);
    acked = 0;
    repeat (12) begin
      @(negedge clk);
      if (!vme_dtack_n) acked = 1;
    end
    chk(req, "no ack on rejected cycle", {31'd0, acked}, 0);
    vme_as_n = 1'b1;
    vme_ds_n = 2'b11;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "dtack_n after reset", {31'd0, vme_dtack_n}, 1);
    chk("R1", "oe after reset", {31'd0, vme_data_oe}, 0);
    chk("R1", "strobes after reset", {30'd0, eng_we, eng_re}, 0);

    good_cycle(19'h70000, 1, 2'b00, 16'h1234, "R2");
    good_cycle(19'h70020, 1, 2'b00, 16'hBEEF, "R5");
    good_cycle(19'h70010, 0, 2'b00, 16'h0000, "R3");
    good_cycle(19'h70004, 1, 2'b10, 16'h00C3, "R4");
    good_cycle(19'h70006, 1, 2'b01, 16'h7E00, "R4");
    good_cycle(19'h7001E, 0, 2'b10, 16'h0000, "R4");

    bad_cycle(BASE, 19'h6FFFE, AM_OK, 1'b1, "R5");
    bad_cycle(BASE, 19'h70022, AM_OK, 1'b1, "R5");
    bad_cycle(5'h0C, 19'h70000, AM_OK, 1'b1, "R6");
    bad_cycle(BASE, 19'h70000, 6'h3D, 1'b1, "R6");
    bad_cycle(BASE, 19'h70000, AM_OK, 1'b0, "R6");

    // R7: strobe held low after rejection, address turns valid: no response
    begin
      bit acked;
      @(negedge clk);
      drive(BASE, 19'h60000, AM_OK, 1'b1, 1'b0, 2'b00, 16'h5555);
      repeat (8) @(negedge clk);
      vme_addr = {BASE, 19'h70002};
      acked = 0;
      repeat (10) begin
        @(negedge clk);
        if (!vme_dtack_n) acked = 1;
      end
      chk("R7", "no ack while strobe held", {31'd0, acked}, 0);
      vme_as_n = 1'b1;
      vme_ds_n = 2'b11;
    end
    // R7: out-of-window then valid, back to back
    @(negedge clk);
    drive(BASE, 19'h70040, AM_OK, 1'b1, 1'b0, 2'b00, 16'h1111);
    repeat (5) @(negedge clk);
    vme_as_n = 1'b1;
    vme_ds_n = 2'b11;
    good_cycle(19'h70008, 1, 2'b00, 16'h4242, "R7");

    // R8: dtack held while one strobe still low
    begin
      exp_t e;
      int cnt;
      bit rose;
      @(negedge clk);
      e.wr = 1; e.a = 6'h0C; e.be = 2'b11; e.d = 16'h0F0F; e.req = "R8";
      q.push_back(e);
      drive(BASE, 19'h7000C, AM_OK, 1'b1, 1'b0, 2'b00, 16'h0F0F);
      cnt = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        cnt++;
        if (!vme_dtack_n) break;
      end
      chk("R8", "ack latency", cnt, 5);
      vme_ds_n = 2'b01;
      rose = 0;
      repeat (6) begin
        @(negedge clk);
        if (vme_dtack_n) rose = 1;
      end
      chk("R8", "dtack held with one strobe low", {31'd0, rose}, 0);
      release_and_check("R8");
    end

    repeat (4) @(negedge clk);
    chk("R2", "pending expected strobes", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule